// File: doc/BRIEF.md
# Boot ROM Overlay Controller

This block sits next to the address decoder of a 68000-style bus. It decides, for each bus access, whether the boot ROM or the RAM is enabled. After reset it places the ROM over the bottom of the address space. The processor therefore fetches its reset vectors and first instructions from ROM even though that region normally belongs to RAM. While this boot map is in force, RAM is never selected.

The first strobed access that lands in the ROM's own window arms a sticky flag. The window is a parameterised block range at the top of the upper address bits, or is flagged by the external decoder's ROM select. At the end of that bus cycle, when the strobe drops, the block switches to the normal map. RAM answers at low addresses again, and the ROM answers only inside its own window. The map changes only between bus cycles, so an access in progress never sees its enables change. Boot code only has to jump into the ROM window. It needs no write to a control register. Only a reset brings the boot map back.

Top module: `boot_rom_overlay`

## Requirements
- R1: After reset is released, a strobed access at upper address 0x00 enables the ROM (rom_en_o=1) and not the RAM.
- R2: In the boot map, ram_en_o stays 0 for every address and every strobe state.
- R3: In the boot map, a strobed access whose upper address is below BOOT_BLOCKS (default 2, so 0x00 and 0x01) enables the ROM.
- R4: In the boot map, a strobed access to a RAM address at or above BOOT_BLOCKS and outside the ROM window (for example 0x10) enables neither memory.
- R5: A strobed access whose upper address lies in [ROM_BASE, ROM_BASE+ROM_BLOCKS) (default 0xFE..0xFF) enables the ROM. It arms the switch to the normal map, and the switch takes effect in the first clock after the strobe is seen low.
- R6: A strobed access with rom_dec_i=1 counts as a ROM-window access for R5, even when the address lies outside the window.
- R7: In the normal map, the ROM is enabled only for ROM-window accesses. RAM is enabled for strobed upper addresses below RAM_BLOCKS (default 128). The two enables are never both 1.
- R8: Once the normal map is in force it stays until reset. Asserting rst_n=0 returns the block to the boot map.
- R9: With the address strobe inactive, both enables are 0.
- R10: A ROM-window address or rom_dec_i=1 presented without the strobe does not arm the switch.
- R11: While the strobe stays asserted across clocks, the map in use does not change, even after a ROM-window hit has armed the switch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| strobe_i | input | 1 | Address strobe, active high |
| addr_hi_i | input | HI_W (8) | Upper address bits of the current access |
| rom_dec_i | input | 1 | External decoder's ROM-window select, active high |
| rom_en_o | output | 1 | ROM chip enable, active high |
| ram_en_o | output | 1 | RAM enable, active high |

## Verification
The bench checks whether a ROM-window hit that arrives in the middle of a held strobe switches the map too early. Such a design would drop the ROM enable, or raise the RAM enable, inside a single access. The bench also checks that window addresses and decoder selects presented without the strobe leave the boot map alone. A design that ignored the strobe there would hand low addresses to RAM before the boot code had left them. Further cases cover the sticky flag surviving many idle and RAM cycles, the return to boot after a later reset, and the external select arming the switch for an address outside the window. A design that lost the flag would send vector fetches back to ROM, and one that ignored the select would never leave the boot map on such systems.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;
  // True when block index blk lies in [base, base+count).
  function automatic logic blk_in_range(input int unsigned blk,
                                        input int unsigned base,
                                        input int unsigned count);
    return (blk >= base) && (blk < base + count);
  endfunction

  typedef enum logic {MAP_BOOT = 1'b0, MAP_NORMAL = 1'b1} map_e;
endpackage

// File: rtl/ovl_window_decode.sv
module ovl_window_decode
  import boot_ovl_pkg::*;
#(
  parameter int unsigned HI_W        = 8,
  parameter int unsigned ROM_BASE    = 254,
  parameter int unsigned ROM_BLOCKS  = 2,
  parameter int unsigned BOOT_BLOCKS = 2,
  parameter int unsigned RAM_BLOCKS  = 128
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic            rom_dec,
  output logic            rom_hit,
  output logic            boot_hit,
  output logic            ram_hit
);
  logic [31:0] blk;
  assign blk = 32'(addr_hi);

  always_comb begin
    rom_hit  = rom_dec | blk_in_range(blk, ROM_BASE, ROM_BLOCKS);
    boot_hit = blk_in_range(blk, 0, BOOT_BLOCKS);
    ram_hit  = blk_in_range(blk, 0, RAM_BLOCKS) & ~rom_hit;
  end
endmodule

// File: rtl/ovl_map_state.sv
module ovl_map_state
  import boot_ovl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic rom_hit,
  output logic armed,
  output map_e map_q
);
  logic arm_evt;   // strobed ROM-window access seen this clock
  logic swap_evt;  // between bus cycles: armed switch may take effect

  assign arm_evt  = strobe & rom_hit;
  assign swap_evt = ~strobe & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      map_q <= MAP_BOOT;
    end else begin
      if (arm_evt)  armed <= 1'b1;
      if (swap_evt) map_q <= MAP_NORMAL;
    end
  end

  AST_ARM_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    arm_evt |=> armed); // R5
  AST_MAP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (map_q == MAP_NORMAL) |=> (map_q == MAP_NORMAL)); // R8
  AST_HELD_STROBE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && $past(strobe)) |-> $stable(map_q)); // R11
  AST_NO_ARM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !strobe) |=> !armed); // R10
endmodule

// File: rtl/ovl_select.sv
module ovl_select
  import boot_ovl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  map_e map_q,
  input  logic rom_hit,
  input  logic boot_hit,
  input  logic ram_hit,
  output logic rom_en,
  output logic ram_en
);
  logic overlay_on;
  assign overlay_on = (map_q == MAP_BOOT);

  always_comb begin
    rom_en = strobe & (rom_hit | (overlay_on & boot_hit));
    ram_en = strobe & ~overlay_on & ram_hit;
  end

  AST_BOOT_NO_RAM: assert property (@(posedge clk) disable iff (!rst_n)
    overlay_on |-> !ram_en); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |-> (!rom_en && !ram_en)); // R9
  AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rom_en, ram_en})); // R7
endmodule

// File: rtl/boot_rom_overlay.sv
module boot_rom_overlay
  import boot_ovl_pkg::*;
#(
  parameter int unsigned HI_W        = 8,
  parameter int unsigned ROM_BLOCKS  = 2,
  parameter int unsigned BOOT_BLOCKS = 2,
  parameter int unsigned RAM_BLOCKS  = 128
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            strobe_i,
  input  logic [HI_W-1:0] addr_hi_i,
  input  logic            rom_dec_i,
  output logic            rom_en_o,
  output logic            ram_en_o
);
  localparam int unsigned SPAN     = 1 << HI_W;
  localparam int unsigned ROM_BASE = SPAN - ROM_BLOCKS;

  logic rom_hit, boot_hit, ram_hit, armed;
  map_e map_q;

  ovl_window_decode #(
    .HI_W(HI_W), .ROM_BASE(ROM_BASE), .ROM_BLOCKS(ROM_BLOCKS),
    .BOOT_BLOCKS(BOOT_BLOCKS), .RAM_BLOCKS(RAM_BLOCKS)
  ) u_dec (
    .addr_hi(addr_hi_i), .rom_dec(rom_dec_i),
    .rom_hit(rom_hit), .boot_hit(boot_hit), .ram_hit(ram_hit)
  );

  ovl_map_state u_state (
    .clk(clk), .rst_n(rst_n), .strobe(strobe_i), .rom_hit(rom_hit),
    .armed(armed), .map_q(map_q)
  );

  ovl_select u_sel (
    .clk(clk), .rst_n(rst_n), .strobe(strobe_i), .map_q(map_q),
    .rom_hit(rom_hit), .boot_hit(boot_hit), .ram_hit(ram_hit),
    .rom_en(rom_en_o), .ram_en(ram_en_o)
  );

  AST_WINDOW_ROM: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && rom_hit) |-> (rom_en_o && !ram_en_o)); // R5
  AST_SWITCH_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(map_q == MAP_NORMAL) |-> $past(armed)); // R10
endmodule

// File: tb/tb_boot_rom_overlay.sv
module tb_boot_rom_overlay;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strobe = 1'b0;
  logic [7:0] addr = 8'h00;
  logic dec = 1'b0;
  logic rom_en, ram_en;

  int checks = 0;
  int fails = 0;
  bit m_pending = 0;
  bit m_normal = 0;

  always #4 clk = ~clk;

  boot_rom_overlay dut (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .addr_hi_i(addr),
    .rom_dec_i(dec), .rom_en_o(rom_en), .ram_en_o(ram_en)
  );

  // Reference model: pending flag follows any strobed window access;
  // normal map adopted at the first clock where the strobe is low.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pending <= 0;
      m_normal  <= 0;
    end else begin
      if (strobe && (int'(addr) >= 254 || dec)) m_pending <= 1;
      if (!strobe && m_pending) m_normal <= 1;
    end
  end

  task automatic step(input bit s, input int a, input bit d, input string req);
    bit win, exp_rom, exp_ram;
    strobe = s; addr = 8'(a); dec = d;
    @(negedge clk);
    win = (a >= 254) || d;
    exp_rom = s && (win || (!m_normal && a < 2));
    exp_ram = s && m_normal && a < 128 && !win;
    checks++;
    if (rom_en !== exp_rom || ram_en !== exp_ram) begin
      fails++;
      $display("FAIL %s: rom_en=%b ram_en=%b expected rom_en=%b ram_en=%b (a=%0h s=%b d=%b)",
               req, rom_en, ram_en, exp_rom, exp_ram, a, s, d);
    end
  endtask

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0;
    for (int i = 0; i < 3; i++) step(0, 0, 0, "R9");
    rst_n = 1;
    step(0, 0, 0, "R9");
    step(1, 8'h00, 0, "R1");
    step(1, 8'h01, 0, "R3");
    step(1, 8'h10, 0, "R4");
    step(1, 8'h7F, 0, "R2");
    step(0, 8'h02, 0, "R9");
    // window and decoder select without strobe must not arm
    for (int i = 0; i < 3; i++) step(0, 8'hFE, 1, "R10");
    step(0, 8'h00, 0, "R10");
    step(1, 8'h00, 0, "R10");
    step(0, 8'h00, 0, "R10");
    // held strobe over window hit, then address changes inside held strobe
    for (int i = 0; i < 3; i++) step(1, 8'hFE, 0, "R5");
    step(1, 8'h00, 0, "R11");
    step(1, 8'h10, 0, "R11");
    step(0, 8'h00, 0, "R5");
    step(1, 8'h00, 0, "R5");
    step(1, 8'h10, 0, "R7");
    step(1, 8'hFF, 0, "R7");
    step(1, 8'h90, 0, "R7");
    step(1, 8'h01, 0, "R7");
    for (int i = 0; i < 20; i++) step(i % 2, i * 5, 0, "R8");
    step(1, 8'h00, 0, "R8");
    // reset returns to boot map
    rst_n = 0;
    step(0, 0, 0, "R8");
    rst_n = 1;
    step(1, 8'h00, 0, "R8");
    step(1, 8'h20, 0, "R2");
    step(0, 0, 0, "R9");
    // external decoder select arms the switch for an out-of-window address
    step(1, 8'h40, 1, "R6");
    step(1, 8'h40, 1, "R6");
    step(0, 8'h00, 0, "R6");
    step(1, 8'h00, 0, "R6");
    step(1, 8'h40, 0, "R6");
    step(0, 8'h00, 0, "R9");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule